// File: doc/BRIEF.md
# Memory-Mapped Nanosecond Alarm Timer

This peripheral keeps a free-running 64-bit time count in nanoseconds. The count grows by a fixed, parameterised number of nanoseconds on every clock cycle. A single 64-bit alarm value is compared against the count. When the alarm fires, it raises a pending flag, and a level interrupt line follows that flag, gated by an enable bit.

Software reaches the block through a plain 32-bit register bus with one-cycle read and write strobes. Read data is combinational in the strobe cycle.

Software reads the time as two words. Reading the low word captures the high word into a holding register, so the 64-bit value read is coherent. Either time word can be overwritten, and counting continues from the new value.

Writing the upper alarm word only stores it. Writing the lower alarm word stores it and arms the alarm. An alarm already at or behind the count fires at once; otherwise the alarm stays running until the count reaches it.

Top module: `ns_alarm_timer`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: the count, the alarm value, the running flag, the pending flag, the enable bit and `irq_o`.
- R2: With no write to offset 0x00 or 0x04, the count grows by NS_PER_CLK every clock cycle, and carries from the low word into the high word.
- R3: A read of offset 0x00 returns the low 32 bits of the current count and copies the high 32 bits into a holding register. A read of offset 0x04 returns that holding register, not the live high word.
- R4: A write to offset 0x00 replaces the low half of the count, and a write to 0x04 replaces the high half. The other half keeps its value, and one cycle later the count has advanced by NS_PER_CLK from the merged value.
- R5: A write to offset 0x0C stores the upper alarm word only. A write to offset 0x08 stores the lower alarm word and arms the alarm. Both words read back at their offsets.
- R6: When the alarm is armed and the new 64-bit alarm value is less than or equal to the count in the write cycle, pending is set on the next cycle and the running flag stays clear.
- R7: When the alarm is armed and the new value is greater than the count, the running flag sets. The alarm fires in the first cycle where the count is greater than or equal to the alarm: running then clears and pending sets.
- R8: `irq_o` is high exactly when pending and enable are both set. A write to offset 0x10 keeps only bit 0 as the enable bit, and a read of 0x10 returns it in bit 0.
- R9: A write to offset 0x14 clears the running flag and leaves pending as it was. A write to offset 0x1C clears pending, unless an alarm fires in the same cycle, in which case pending stays set.
- R10: Reads of offsets 0x14, 0x1C, or any offset outside the list above (including offsets that are not word-aligned) return zero. Writes to offset 0x18 or to unlisted offsets change nothing.
- R11: A read of offset 0x18 returns the running flag in bit 0, with the other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count advances on every rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle `bus_rd` is high, zero otherwise |
| irq_o | output | 1 | Level interrupt: pending AND enable |

## Verification
The bound checker watches several rules on every clock:
- the count stepping by the increment when no time word is written;
- the holding register capturing the high word on a low-word read;
- a running alarm that reaches the count setting pending and clearing running;
- arming into the past firing at once;
- an alarm disarm leaving pending untouched;
- the interrupt staying low while disabled.

Other behaviours are shown only by the bench's scenarios, against its own model of the register file:
- the coherence of a two-word time read across a carry;
- the merge of a half-word time write;
- an alarm armed exactly at the current count;
- the firing cycle of a future alarm;
- zero reads and ignored writes at unlisted offsets.

// File: rtl/nsat_pkg.sv
// Package: shared offsets and types for the nanosecond alarm timer.
// Assumes byte offsets on a 32-bit register bus; only exact offsets decode.
package nsat_pkg;

    localparam logic [7:0] OFF_TIME_LO  = 8'h00;
    localparam logic [7:0] OFF_TIME_HI  = 8'h04;
    localparam logic [7:0] OFF_ALRM_LO  = 8'h08;
    localparam logic [7:0] OFF_ALRM_HI  = 8'h0C;
    localparam logic [7:0] OFF_IRQ_EN   = 8'h10;
    localparam logic [7:0] OFF_DISARM   = 8'h14;
    localparam logic [7:0] OFF_STATUS   = 8'h18;
    localparam logic [7:0] OFF_ACK      = 8'h1C;

    // Register selected by the current bus address
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_TIME_LO,
        SEL_TIME_HI,
        SEL_ALRM_LO,
        SEL_ALRM_HI,
        SEL_IRQ_EN,
        SEL_DISARM,
        SEL_STATUS,
        SEL_ACK
    } reg_sel_e;

    // One-cycle action strobes produced by the decoder
    typedef struct packed {
        logic rd_time_lo;
        logic wr_time_lo;
        logic wr_time_hi;
        logic wr_alrm_lo;
        logic wr_alrm_hi;
        logic wr_irq_en;
        logic wr_disarm;
        logic wr_ack;
    } strobes_t;

endpackage

// File: rtl/nsat_decode.sv
// Module: nsat_decode
// Decodes the bus offset into a register select and action strobes, and
// multiplexes read data. Assumes at most one of rd/wr per cycle is meaningful;
// unlisted or unaligned offsets select nothing and read as zero.
module nsat_decode
    import nsat_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] time_lo,
    input  logic [DATA_W-1:0] time_hi_hold,
    input  logic [DATA_W-1:0] alrm_lo,
    input  logic [DATA_W-1:0] alrm_hi,
    input  logic              irq_en,
    input  logic              running,
    output strobes_t          stb,
    output logic [DATA_W-1:0] rdata
);

    reg_sel_e sel;

    // Map the exact byte offset onto a register select
    always_comb begin
        sel = SEL_NONE;
        if      (addr == ADDR_W'(OFF_TIME_LO)) sel = SEL_TIME_LO;
        else if (addr == ADDR_W'(OFF_TIME_HI)) sel = SEL_TIME_HI;
        else if (addr == ADDR_W'(OFF_ALRM_LO)) sel = SEL_ALRM_LO;
        else if (addr == ADDR_W'(OFF_ALRM_HI)) sel = SEL_ALRM_HI;
        else if (addr == ADDR_W'(OFF_IRQ_EN))  sel = SEL_IRQ_EN;
        else if (addr == ADDR_W'(OFF_DISARM))  sel = SEL_DISARM;
        else if (addr == ADDR_W'(OFF_STATUS))  sel = SEL_STATUS;
        else if (addr == ADDR_W'(OFF_ACK))     sel = SEL_ACK;
    end

    // Turn the select plus strobes into per-register actions
    always_comb begin
        stb            = '0;
        stb.rd_time_lo = rd && (sel == SEL_TIME_LO);
        stb.wr_time_lo = wr && (sel == SEL_TIME_LO);
        stb.wr_time_hi = wr && (sel == SEL_TIME_HI);
        stb.wr_alrm_lo = wr && (sel == SEL_ALRM_LO);
        stb.wr_alrm_hi = wr && (sel == SEL_ALRM_HI);
        stb.wr_irq_en  = wr && (sel == SEL_IRQ_EN);
        stb.wr_disarm  = wr && (sel == SEL_DISARM);
        stb.wr_ack     = wr && (sel == SEL_ACK);
    end

    // Read multiplexer; write-only and unlisted offsets return zero
    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (sel)
                SEL_TIME_LO: rdata = time_lo;
                SEL_TIME_HI: rdata = time_hi_hold;
                SEL_ALRM_LO: rdata = alrm_lo;
                SEL_ALRM_HI: rdata = alrm_hi;
                SEL_IRQ_EN:  rdata = DATA_W'(irq_en);
                SEL_STATUS:  rdata = DATA_W'(running);
                default:     rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/nsat_count.sv
// Module: nsat_count
// Free-running nanosecond count of two DATA_W halves with a high-word holding
// register for coherent two-word reads. Assumes a write hits at most one half
// per cycle; a written half takes the bus value, the other keeps its own.
module nsat_count #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NS_PER_CLK = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic                snap,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*DATA_W-1:0] cnt,
    output logic [DATA_W-1:0]   hi_hold
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt_q;
    logic [DATA_W-1:0] hold_q;

    // Advance the count, or replace one half of it on a software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_lo) begin
            cnt_q <= {cnt_q[CNT_W-1:DATA_W], wdata};
        end else if (wr_hi) begin
            cnt_q <= {wdata, cnt_q[DATA_W-1:0]};
        end else begin
            cnt_q <= cnt_q + CNT_W'(NS_PER_CLK);
        end
    end

    // Capture the upper half whenever software reads the lower half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (snap) begin
            hold_q <= cnt_q[CNT_W-1:DATA_W];
        end
    end

    assign cnt     = cnt_q;
    assign hi_hold = hold_q;

endmodule

// File: rtl/nsat_alarm.sv
// Module: nsat_alarm
// Alarm value, running flag, pending flag and interrupt enable. Assumes the
// count input is the registered count; arming compares the newly merged value
// against it, and a running alarm fires once the count reaches the alarm.
module nsat_alarm #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic                wr_en,
    input  logic                wr_disarm,
    input  logic                wr_ack,
    output logic [2*DATA_W-1:0] alarm,
    output logic                running,
    output logic                pending,
    output logic                enable
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] alarm_q;
    logic [CNT_W-1:0] alarm_armed;
    logic             run_q;
    logic             pend_q;
    logic             en_q;
    logic             fire_run;
    logic             fire_arm;

    // Candidate alarm value when the low word is written this cycle
    always_comb alarm_armed = {alarm_q[CNT_W-1:DATA_W], wdata};

    // Firing conditions: a running alarm reached, or armed into the past
    always_comb begin
        fire_run = run_q && (cnt >= alarm_q);
        fire_arm = wr_lo && (alarm_armed <= cnt);
    end

    // Hold the alarm words as software writes them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
        end else if (wr_lo) begin
            alarm_q <= alarm_armed;
        end else if (wr_hi) begin
            alarm_q <= {wdata, alarm_q[DATA_W-1:0]};
        end
    end

    // Running flag: arming decides, disarm clears, firing clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (wr_lo) begin
            run_q <= !fire_arm;
        end else if (wr_disarm || fire_run) begin
            run_q <= 1'b0;
        end
    end

    // Pending flag: any firing sets it, acknowledge clears it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (fire_run || fire_arm) begin
            pend_q <= 1'b1;
        end else if (wr_ack) begin
            pend_q <= 1'b0;
        end
    end

    // Interrupt enable keeps bit 0 of the written word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (wr_en) begin
            en_q <= wdata[0];
        end
    end

    assign alarm   = alarm_q;
    assign running = run_q;
    assign pending = pend_q;
    assign enable  = en_q;

endmodule

// File: rtl/ns_alarm_timer.sv
// Module: ns_alarm_timer
// Top of the nanosecond alarm timer: bus decode, count and alarm logic, and
// the level interrupt output. Assumes single-cycle 32-bit accesses; the read
// data is combinational in the cycle the read strobe is high.
module ns_alarm_timer
    import nsat_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned NS_PER_CLK = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    strobes_t          stb;
    logic [CNT_W-1:0]  cnt_w;
    logic [DATA_W-1:0] hold_w;
    logic [CNT_W-1:0]  alarm_w;
    logic              run_w;
    logic              pend_w;
    logic              en_w;

    nsat_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .addr         (bus_addr),
        .rd           (bus_rd),
        .wr           (bus_wr),
        .time_lo      (cnt_w[DATA_W-1:0]),
        .time_hi_hold (hold_w),
        .alrm_lo      (alarm_w[DATA_W-1:0]),
        .alrm_hi      (alarm_w[CNT_W-1:DATA_W]),
        .irq_en       (en_w),
        .running      (run_w),
        .stb          (stb),
        .rdata        (bus_rdata)
    );

    nsat_count #(.DATA_W(DATA_W), .NS_PER_CLK(NS_PER_CLK)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (stb.wr_time_lo),
        .wr_hi   (stb.wr_time_hi),
        .snap    (stb.rd_time_lo),
        .wdata   (bus_wdata),
        .cnt     (cnt_w),
        .hi_hold (hold_w)
    );

    nsat_alarm #(.DATA_W(DATA_W)) u_alm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (cnt_w),
        .wdata     (bus_wdata),
        .wr_lo     (stb.wr_alrm_lo),
        .wr_hi     (stb.wr_alrm_hi),
        .wr_en     (stb.wr_irq_en),
        .wr_disarm (stb.wr_disarm),
        .wr_ack    (stb.wr_ack),
        .alarm     (alarm_w),
        .running   (run_w),
        .pending   (pend_w),
        .enable    (en_w)
    );

    // Level interrupt follows the gated pending flag
    always_comb irq_o = pend_w && en_w;

endmodule

// File: rtl/nsat_checker.sv
// Module: nsat_checker
// Cycle-level rules of the alarm timer, bound to the top module. Assumes it
// sees the registered count, holding word, alarm and flags of the top.
module nsat_checker
    import nsat_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned NS_PER_CLK = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                rd,
    input logic                wr,
    input logic [DATA_W-1:0]   wdata,
    input logic                irq,
    input logic [2*DATA_W-1:0] cnt,
    input logic [DATA_W-1:0]   hold,
    input logic [2*DATA_W-1:0] alarm,
    input logic                run,
    input logic                pend,
    input logic                en
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    logic time_wr;
    logic arm_wr;
    logic disarm_wr;
    logic lo_rd;

    // Decode the bus cycle kinds the properties refer to
    always_comb begin
        time_wr   = wr && (addr == ADDR_W'(OFF_TIME_LO) || addr == ADDR_W'(OFF_TIME_HI));
        arm_wr    = wr && (addr == ADDR_W'(OFF_ALRM_LO));
        disarm_wr = wr && (addr == ADDR_W'(OFF_DISARM));
        lo_rd     = rd && (addr == ADDR_W'(OFF_TIME_LO));
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !time_wr |=> cnt == $past(cnt) + CNT_W'(NS_PER_CLK));

    // R3
    hold_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |=> hold == $past(cnt[CNT_W-1:DATA_W]));

    // R6
    arm_past_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_wr && ({alarm[CNT_W-1:DATA_W], wdata} <= cnt)) |=> (pend && !run));

    // R7
    run_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (cnt >= alarm) && !arm_wr && !disarm_wr) |=> (pend && !run));

    // R9
    disarm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disarm_wr && !(run && (cnt >= alarm))) |=> (!run && pend == $past(pend)));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !irq);

endmodule

bind ns_alarm_timer nsat_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NS_PER_CLK(NS_PER_CLK)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .rd    (bus_rd),
    .wr    (bus_wr),
    .wdata (bus_wdata),
    .irq   (irq_o),
    .cnt   (cnt_w),
    .hold  (hold_w),
    .alarm (alarm_w),
    .run   (run_w),
    .pend  (pend_w),
    .en    (en_w)
);

// File: tb/sim_ns_alarm_timer.sv
`timescale 1ns/1ps
module sim_ns_alarm_timer;

    localparam int unsigned DW  = 32;
    localparam int unsigned AW  = 6;
    localparam int unsigned INC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // Bench model of the register file
    logic [63:0] m_cnt, m_al;
    logic [31:0] m_sh;
    logic        m_run, m_pend, m_en;

    ns_alarm_timer #(.DATA_W(DW), .ADDR_W(AW), .NS_PER_CLK(INC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run did not finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        case (a)
            6'h00:   return m_cnt[31:0];
            6'h04:   return m_sh;
            6'h08:   return m_al[31:0];
            6'h0C:   return m_al[63:32];
            6'h10:   return {31'b0, m_en};
            6'h18:   return {31'b0, m_run};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [AW-1:0] a);
        case (a)
            6'h00:   return "R2";
            6'h04:   return "R3";
            6'h08, 6'h0C: return "R5";
            6'h10:   return "R8";
            6'h18:   return "R11";
            default: return "R10";
        endcase
    endfunction

    task automatic model_step(input bit rd, input bit wr, input logic [AW-1:0] a, input logic [31:0] d);
        logic        fire, imm, n_run, n_pend;
        logic [63:0] n_cnt, n_al;
        fire  = m_run && (m_cnt >= m_al);
        imm   = 1'b0;
        n_cnt = m_cnt + 64'(INC);
        if (wr && a == 6'h00) n_cnt = {m_cnt[63:32], d};
        if (wr && a == 6'h04) n_cnt = {d, m_cnt[31:0]};
        if (rd && a == 6'h00) m_sh = m_cnt[63:32];
        n_al  = m_al;
        n_run = fire ? 1'b0 : m_run;
        if (wr && a == 6'h08) begin
            n_al  = {m_al[63:32], d};
            imm   = (n_al <= m_cnt);
            n_run = !imm;
        end
        if (wr && a == 6'h0C) n_al = {d, m_al[31:0]};
        if (wr && a == 6'h14) n_run = 1'b0;
        if (wr && a == 6'h10) m_en = d[0];
        n_pend = (fire || imm) ? 1'b1 : ((wr && a == 6'h1C) ? 1'b0 : m_pend);
        m_cnt  = n_cnt;
        m_al   = n_al;
        m_run  = n_run;
        m_pend = n_pend;
    endtask

    // One bus cycle: called at a falling edge, returns at the next falling edge
    task automatic bus_op(input bit rd, input bit wr, input logic [AW-1:0] a,
                          input logic [31:0] d, input string tag);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1;
        if (rd) chk(tag, bus_rdata, model_read(a));
        chk("R8 irq", {31'b0, irq_o}, {31'b0, m_pend & m_en});
        @(posedge clk);
        model_step(rd, wr, a, d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bus_op(1'b0, 1'b0, '0, '0, "R8");
    endtask

    task automatic rd_op(input logic [AW-1:0] a, input string tag);
        bus_op(1'b1, 1'b0, a, '0, tag);
    endtask

    task automatic wr_op(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        bus_op(1'b0, 1'b1, a, d, tag);
    endtask

    initial begin
        logic [63:0] tgt;
        void'($urandom(32'h1A2B3C4D));
        m_cnt = '0; m_al = '0; m_sh = '0; m_run = 0; m_pend = 0; m_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen through the bus
        rd_op(6'h00, "R1 count");
        rd_op(6'h08, "R1 alarm lo");
        rd_op(6'h0C, "R1 alarm hi");
        rd_op(6'h10, "R1 enable");
        rd_op(6'h18, "R1 running");
        chk("R1 irq", {31'b0, irq_o}, 32'h0);

        // R2: steady advance
        idle(3);
        rd_op(6'h00, "R2 advance");
        rd_op(6'h04, "R3 hold");

        // R4 then R2 carry, R3 coherence across the carry
        wr_op(6'h00, 32'hFFFF_FFF0, "R4 low write");
        rd_op(6'h00, "R4 low merged");
        idle(6);
        rd_op(6'h04, "R3 hold keeps old high");
        rd_op(6'h00, "R2 after carry");
        rd_op(6'h04, "R3 high after carry");
        wr_op(6'h04, 32'h0000_00A5, "R4 high write");
        rd_op(6'h00, "R4 low kept");
        rd_op(6'h04, "R4 high merged");

        // R8: enable keeps bit 0 only
        wr_op(6'h10, 32'hFFFF_FFFF, "R8 enable");
        rd_op(6'h10, "R8 enable readback");

        // R5/R6: alarm in the past fires at once
        wr_op(6'h0C, 32'h0, "R5 alarm hi");
        rd_op(6'h0C, "R5 alarm hi readback");
        rd_op(6'h18, "R5 not armed by hi");
        wr_op(6'h08, 32'h5, "R6 arm past");
        rd_op(6'h18, "R11 running clear");
        chk("R6 irq raised", {31'b0, irq_o}, 32'h1);
        wr_op(6'h1C, 32'h0, "R9 ack");
        chk("R9 irq cleared", {31'b0, irq_o}, 32'h0);

        // R7: future alarm
        tgt = m_cnt + 64'd48;
        wr_op(6'h0C, tgt[63:32], "R5 alarm hi");
        wr_op(6'h08, tgt[31:0], "R7 arm future");
        rd_op(6'h18, "R11 running set");
        rd_op(6'h08, "R5 alarm lo readback");
        idle(14);
        rd_op(6'h18, "R7 running cleared by fire");
        chk("R7 irq after fire", {31'b0, irq_o}, 32'h1);
        wr_op(6'h1C, 32'h0, "R9 ack");

        // R6: alarm equal to the count of the write cycle
        tgt = m_cnt + 64'(INC);
        wr_op(6'h0C, tgt[63:32], "R5 alarm hi");
        wr_op(6'h08, m_cnt[31:0], "R6 arm equal");
        chk("R6 equal fires", {31'b0, irq_o}, 32'h1);

        // R9: disarm leaves pending
        tgt = m_cnt + 64'd4000;
        wr_op(6'h0C, tgt[63:32], "R5 alarm hi");
        wr_op(6'h08, tgt[31:0], "R9 arm far");
        wr_op(6'h14, 32'h0, "R9 disarm");
        rd_op(6'h18, "R9 running cleared");
        chk("R9 pending kept", {31'b0, irq_o}, 32'h1);

        // R10: ignored writes, zero reads
        wr_op(6'h18, 32'h1, "R10 status write");
        rd_op(6'h18, "R10 status unchanged");
        wr_op(6'h20, 32'hDEAD_BEEF, "R10 write 0x20");
        wr_op(6'h01, 32'h1234_5678, "R10 unaligned write");
        wr_op(6'h3C, 32'hFFFF_FFFF, "R10 write 0x3C");
        rd_op(6'h00, "R10 count untouched");
        rd_op(6'h14, "R10 read disarm");
        rd_op(6'h1C, "R10 read ack");
        rd_op(6'h20, "R10 read 0x20");
        rd_op(6'h02, "R10 read unaligned");

        // R8: disabled gate
        wr_op(6'h10, 32'h2, "R8 disable");
        chk("R8 irq gated", {31'b0, irq_o}, 32'h0);
        rd_op(6'h10, "R8 enable readback");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            logic [AW-1:0] a;
            r = $urandom % 10;
            a = AW'({$urandom % 16, 2'b00});
            case (r)
                0, 1, 2: idle(1);
                3:       rd_op(a, tag_of(a));
                4:       wr_op(6'h08, m_cnt[31:0] + ($urandom % 200), "R7");
                5:       wr_op(6'h0C, m_cnt[63:32], "R5");
                6:       wr_op(6'h10, $urandom, "R8");
                7:       wr_op(($urandom % 2) ? 6'h1C : 6'h14, '0, "R9");
                8:       wr_op(($urandom % 2) ? 6'h00 : 6'h04, $urandom, "R4");
                default: wr_op(AW'($urandom), $urandom, "R10");
            endcase
            if ($urandom % 4 == 0) rd_op(6'h00, "R2");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule